// File: doc/BRIEF.md
# Byte-Range Reservation Monitor for Load-Linked / Store-Conditional

This block tracks atomic reservations for load-linked / store-conditional (LL/SC) pairs. It records each reservation as an inclusive byte range, not as a whole cache line. A load-linked request stores the requesting context and the bytes it read. A later store-conditional from the same context succeeds only when the written bytes lie entirely inside that context's reservation.

Every store removes only the reservations whose bytes it actually touches. This applies to conditional stores, whether they succeed or fail, and to plain stores. A write to another part of the same line therefore leaves an unrelated LL/SC pair intact.

A separate line-invalidate input drops every reservation held in one 64-byte line, for whatever context. The block holds no data. It sits beside the cache write path and returns one pass/fail flag for each store-conditional.

Top module: `llsc_resv_monitor`

## Requirements
- R1: A load-linked request (req_op = 0) records a reservation for req_ctx covering bytes req_addr through req_addr + 2^req_size - 1, inclusive. req_size codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes.
- R2: A store-conditional (req_op = 1) raises sc_done for exactly one cycle, in the cycle after it is accepted. sc_ok is 1 in that cycle only if a live reservation of the same context contains the whole store range. sc_ok is 0 whenever sc_done is 0.
- R3: A store-conditional fails when the only reservation covering its bytes belongs to another context. It also fails when its range extends past either end of the reservation.
- R4: After a store-conditional, whether it passed or failed, every reservation overlapping its byte range is gone, whatever its context. Reservations that do not overlap the range are kept.
- R5: A plain store (req_op = 2) removes every reservation that overlaps its byte range and keeps all others, including reservations elsewhere in the same line.
- R6: When inv_valid is 1, every reservation whose address falls in line inv_line (address bits 31..6) is removed, for every context.
- R7: An invalidate and a request in the same cycle are ordered invalidate first. A same-cycle store-conditional cannot use a reservation in the invalidated line, and a same-cycle load-linked reservation in that line survives.
- R8: Each context holds at most one reservation. A new load-linked request from a context replaces that context's previous reservation.
- R9: The table holds ENTRIES (8) reservations. A load-linked request from a context with no reservation takes the lowest-numbered free entry. When no entry is free it evicts entries in round-robin order, starting at entry 0 after reset and advancing by one on each eviction.
- R10: Op code 3, and any cycle with req_valid low, change no reservation and produce no sc_done. req_ready is always 1.
- R11: After reset no reservation exists and sc_done and sc_ok are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted; always 1 |
| req_op | input | 2 | 0 load-linked, 1 store-conditional, 2 store, 3 no operation |
| req_ctx | input | CTX_W (4) | Requesting context |
| req_addr | input | ADDR_W (32) | Physical byte address |
| req_size | input | 2 | log2 of the byte count |
| inv_valid | input | 1 | Drop all reservations in a line |
| inv_line | input | ADDR_W-6 (26) | Line number, address bits 31..6 |
| sc_done | output | 1 | Store-conditional result valid |
| sc_ok | output | 1 | 1 on store-conditional success |

## Verification
Internal faults in this block surface only through sc_ok, one cycle after a later store-conditional. The bench therefore follows each load-linked request, store and invalidate with store-conditionals chosen to probe it.

A reservation that was cleared too widely shows up as a false failure on the disjoint pair. One that was cleared too narrowly, or evicted from the wrong entry, shows up as a false success. Each such error appears at the first store-conditional that touches the affected context.

A behavioural model of the table checks both outputs on every clock, so a mismatch is reported in the cycle it appears.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic [1:0] {
    OP_LL  = 2'd0,
    OP_SC  = 2'd1,
    OP_ST  = 2'd2,
    OP_NOP = 2'd3
  } llsc_op_e;
endpackage

// File: rtl/llsc_entry_cmp.sv
// Per-entry comparators: context match, containment, overlap, line hit.
module llsc_entry_cmp #(
  parameter int ADDR_W = 32,
  parameter int CTX_W  = 4,
  parameter int OFS_W  = 6
) (
  input  logic              ent_vld,
  input  logic [CTX_W-1:0]  ent_ctx,
  input  logic [ADDR_W-1:0] ent_lo,
  input  logic [ADDR_W-1:0] ent_hi,
  input  logic [CTX_W-1:0]  req_ctx,
  input  logic [ADDR_W-1:0] req_lo,
  input  logic [ADDR_W-1:0] req_hi,
  input  logic              inv_valid,
  input  logic [ADDR_W-OFS_W-1:0] inv_line,
  output logic              live,
  output logic              ctx_hit,
  output logic              contains,
  output logic              overlap
);
  logic line_hit;

  always_comb begin
    line_hit = inv_valid && (ent_lo[ADDR_W-1:OFS_W] == inv_line);
    live     = ent_vld && !line_hit;
    ctx_hit  = live && (ent_ctx == req_ctx);
    contains = ctx_hit && (req_lo >= ent_lo) && (req_hi <= ent_hi);
    overlap  = live && (req_lo <= ent_hi) && (req_hi >= ent_lo);
  end
endmodule

// File: rtl/llsc_victim_sel.sv
// Picks the entry a load-linked request writes: own entry, else lowest
// free, else round-robin victim.
module llsc_victim_sel #(
  parameter int ENTRIES = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               alloc,
  input  logic [ENTRIES-1:0] live,
  input  logic [ENTRIES-1:0] hit,
  output logic [ENTRIES-1:0] victim_oh
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [IDX_W-1:0]   rr_q, rr_d;
  logic               rr_en;
  logic [ENTRIES-1:0] free_vec;
  logic [ENTRIES-1:0] first_free;

  always_comb begin
    free_vec   = ~live;
    first_free = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (free_vec[i]) begin
        first_free    = '0;
        first_free[i] = 1'b1;
      end
    end
  end

  always_comb begin
    rr_en = 1'b0;
    if (|hit) begin
      victim_oh = hit;
    end else if (|free_vec) begin
      victim_oh = first_free;
    end else begin
      victim_oh       = '0;
      victim_oh[rr_q] = 1'b1;
      rr_en           = alloc;
    end
    rr_d = (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rr_q <= '0;
    end else if (rr_en) begin
      rr_q <= rr_d;
    end
  end

  // R8
  hit_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> $onehot0(hit));

  // R9
  victim_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> ($countones(victim_oh) == 1));
endmodule

// File: rtl/llsc_resv_monitor.sv
module llsc_resv_monitor #(
  parameter int ADDR_W     = 32,
  parameter int CTX_W      = 4,
  parameter int ENTRIES    = 8,
  parameter int LINE_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [CTX_W-1:0]  req_ctx,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              inv_valid,
  input  logic [ADDR_W-$clog2(LINE_BYTES)-1:0] inv_line,
  output logic              sc_done,
  output logic              sc_ok
);
  import llsc_pkg::*;

  localparam int OFS_W = $clog2(LINE_BYTES);

  logic              vld_q [ENTRIES];
  logic [CTX_W-1:0]  ctx_q [ENTRIES];
  logic [ADDR_W-1:0] lo_q  [ENTRIES];
  logic [ADDR_W-1:0] hi_q  [ENTRIES];
  logic              vld_d [ENTRIES];

  logic [ENTRIES-1:0] live, ctx_hit, contains, overlap, victim_oh, wr_en;
  logic [ADDR_W-1:0]  req_lo, req_hi, len_m1;
  logic               fire, is_ll, is_sc, is_st, sc_hit;
  logic               sc_done_d, sc_ok_d;
  llsc_op_e           op;

  assign req_ready = 1'b1;

  always_comb begin
    op     = llsc_op_e'(req_op);
    fire   = req_valid && req_ready;
    is_ll  = fire && (op == OP_LL);
    is_sc  = fire && (op == OP_SC);
    is_st  = fire && (op == OP_ST);
    len_m1 = (ADDR_W'(1) << req_size) - ADDR_W'(1);
    req_lo = req_addr;
    req_hi = req_addr + len_m1;
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    llsc_entry_cmp #(
      .ADDR_W (ADDR_W),
      .CTX_W  (CTX_W),
      .OFS_W  (OFS_W)
    ) u_cmp (
      .ent_vld   (vld_q[g]),
      .ent_ctx   (ctx_q[g]),
      .ent_lo    (lo_q[g]),
      .ent_hi    (hi_q[g]),
      .req_ctx   (req_ctx),
      .req_lo    (req_lo),
      .req_hi    (req_hi),
      .inv_valid (inv_valid),
      .inv_line  (inv_line),
      .live      (live[g]),
      .ctx_hit   (ctx_hit[g]),
      .contains  (contains[g]),
      .overlap   (overlap[g])
    );

    always_comb begin
      wr_en[g] = is_ll && victim_oh[g];
      vld_d[g] = wr_en[g] || (live[g] && !((is_sc || is_st) && overlap[g]));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[g] <= 1'b0;
      end else begin
        vld_q[g] <= vld_d[g];
      end
    end

    always_ff @(posedge clk) begin
      if (wr_en[g]) begin
        ctx_q[g] <= req_ctx;
        lo_q[g]  <= req_lo;
        hi_q[g]  <= req_hi;
      end
    end

    // R1
    ll_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_ll && victim_oh[g]) |=> (vld_q[g] && ctx_q[g] == $past(req_ctx) &&
                                   lo_q[g] == $past(req_lo) && hi_q[g] == $past(req_hi)));

    // R4
    store_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_sc || is_st) |=> !(vld_q[g] && lo_q[g] <= $past(req_hi) && hi_q[g] >= $past(req_lo)));

    // R6
    line_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_valid && !is_ll) |=> !(vld_q[g] && lo_q[g][ADDR_W-1:OFS_W] == $past(inv_line)));
  end

  llsc_victim_sel #(
    .ENTRIES (ENTRIES)
  ) u_victim (
    .clk       (clk),
    .rst_n     (rst_n),
    .alloc     (is_ll),
    .live      (live),
    .hit       (ctx_hit),
    .victim_oh (victim_oh)
  );

  always_comb begin
    sc_hit    = |contains;
    sc_done_d = is_sc;
    sc_ok_d   = is_sc && sc_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sc_done <= 1'b0;
      sc_ok   <= 1'b0;
    end else begin
      sc_done <= sc_done_d;
      sc_ok   <= sc_ok_d;
    end
  end

  // R2
  sc_ok_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sc_ok |-> sc_done);

  // R10
  sc_done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sc_done |-> $past(req_valid && req_op == 2'd1));
endmodule

// File: tb/llsc_resv_monitor_test.sv
module llsc_resv_monitor_test;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = 2'd3;
  logic [3:0]  req_ctx = '0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic        inv_valid = 1'b0;
  logic [25:0] inv_line = '0;
  logic        sc_done, sc_ok;

  int    checks = 0;
  int    failures = 0;
  int    cyc = 0;
  bit    finished = 0;
  string tag = "R11";

  // behavioural reference state
  bit          m_vld [N];
  logic [3:0]  m_ctx [N];
  logic [31:0] m_lo  [N];
  logic [31:0] m_hi  [N];
  int          m_rr;
  bit          exp_done, exp_ok;

  llsc_resv_monitor uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_ctx(req_ctx), .req_addr(req_addr), .req_size(req_size),
    .inv_valid(inv_valid), .inv_line(inv_line), .sc_done(sc_done), .sc_ok(sc_ok)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    logic [31:0] lo, hi;
    int slot;
    if (!rst_n) begin
      foreach (m_vld[i]) m_vld[i] = 0;
      m_rr = 0; exp_done = 0; exp_ok = 0;
    end else begin
      if (inv_valid)
        foreach (m_vld[i]) if (m_vld[i] && m_lo[i][31:6] == inv_line) m_vld[i] = 0;
      exp_done = 0; exp_ok = 0;
      if (req_valid) begin
        lo = req_addr;
        hi = req_addr + (32'd1 << req_size) - 32'd1;
        if (req_op == 2'd0) begin
          slot = -1;
          foreach (m_vld[i]) if (slot < 0 && m_vld[i] && m_ctx[i] == req_ctx) slot = i;
          foreach (m_vld[i]) if (slot < 0 && !m_vld[i]) slot = i;
          if (slot < 0) begin slot = m_rr; m_rr = (m_rr + 1) % N; end
          m_vld[slot] = 1; m_ctx[slot] = req_ctx; m_lo[slot] = lo; m_hi[slot] = hi;
        end else if (req_op == 2'd1 || req_op == 2'd2) begin
          if (req_op == 2'd1) begin
            exp_done = 1;
            foreach (m_vld[i])
              if (m_vld[i] && m_ctx[i] == req_ctx && lo >= m_lo[i] && hi <= m_hi[i]) exp_ok = 1;
          end
          foreach (m_vld[i]) if (m_vld[i] && lo <= m_hi[i] && hi >= m_lo[i]) m_vld[i] = 0;
        end
      end
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      checks++;
      if (sc_done !== exp_done || sc_ok !== exp_ok || req_ready !== 1'b1) begin
        failures++;
        $display("FAIL %s model compare: done/ok/ready got %b/%b/%b expected %b/%b/1",
                 tag, sc_done, sc_ok, req_ready, exp_done, exp_ok);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000 && !finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog expired got cycle %0d expected completion", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic step(input bit rv, input logic [1:0] op, input logic [3:0] ctx,
                      input logic [31:0] addr, input logic [1:0] sz,
                      input bit iv, input logic [31:0] iaddr);
    req_valid = rv; req_op = op; req_ctx = ctx; req_addr = addr; req_size = sz;
    inv_valid = iv; inv_line = iaddr[31:6];
    @(negedge clk);
    req_valid = 0; req_op = 2'd3; inv_valid = 0;
  endtask

  task automatic ll(input logic [3:0] ctx, input logic [31:0] a, input logic [1:0] sz);
    step(1, 2'd0, ctx, a, sz, 0, 0);
  endtask

  task automatic st(input logic [3:0] ctx, input logic [31:0] a, input logic [1:0] sz);
    step(1, 2'd2, ctx, a, sz, 0, 0);
  endtask

  task automatic expect_sc(input bit exp_lit);
    checks++;
    if (sc_done !== 1'b1 || sc_ok !== exp_lit) begin
      failures++;
      $display("FAIL %s sc result: done/ok got %b/%b expected 1/%b", tag, sc_done, sc_ok, exp_lit);
    end
  endtask

  task automatic sc(input logic [3:0] ctx, input logic [31:0] a, input logic [1:0] sz,
                    input bit exp_lit);
    step(1, 2'd1, ctx, a, sz, 0, 0);
    expect_sc(exp_lit);
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    do_reset();
    // R11: outputs idle after reset, no reservation
    tag = "R11";
    checks++;
    if (sc_done !== 1'b0 || sc_ok !== 1'b0) begin
      failures++;
      $display("FAIL R11 reset outputs got %b/%b expected 0/0", sc_done, sc_ok);
    end
    sc(4'd0, 32'h0, 2'd0, 0);

    // R1 R2: 4-byte reservation, contained 2-byte SC succeeds
    tag = "R1"; ll(4'd1, 32'h100, 2'd2);
    tag = "R2"; sc(4'd1, 32'h102, 2'd1, 1);
    @(negedge clk);
    // R3: other context fails; R4: that failed SC still clears the reservation
    tag = "R3"; ll(4'd2, 32'h200, 2'd2);
    sc(4'd3, 32'h200, 2'd2, 0);
    tag = "R4"; sc(4'd2, 32'h200, 2'd2, 0);
    // R3: range past reservation end fails
    tag = "R3"; ll(4'd2, 32'h200, 2'd1);
    sc(4'd2, 32'h200, 2'd2, 0);
    ll(4'd2, 32'h204, 2'd2);
    sc(4'd2, 32'h202, 2'd2, 0);
    // R4: successful SC keeps a disjoint reservation
    tag = "R4"; ll(4'd4, 32'h300, 2'd0); ll(4'd5, 32'h308, 2'd3);
    sc(4'd4, 32'h300, 2'd0, 1);
    sc(4'd5, 32'h308, 2'd3, 1);
    // R5: store to a disjoint part of the line keeps, overlapping store kills
    tag = "R5"; ll(4'd6, 32'h400, 2'd2);
    st(4'd9, 32'h404, 2'd2);
    sc(4'd6, 32'h400, 2'd2, 1);
    ll(4'd6, 32'h400, 2'd2);
    st(4'd6, 32'h403, 2'd0);
    sc(4'd6, 32'h400, 2'd2, 0);
    // R6: line invalidate hits all contexts in the line only
    tag = "R6"; ll(4'd7, 32'h500, 2'd2); ll(4'd8, 32'h520, 2'd3); ll(4'd9, 32'h540, 2'd2);
    step(0, 2'd3, 0, 0, 0, 1, 32'h510);
    sc(4'd7, 32'h500, 2'd2, 0);
    sc(4'd8, 32'h520, 2'd3, 0);
    sc(4'd9, 32'h540, 2'd2, 1);
    // R7: invalidate before same-cycle SC and same-cycle LL
    tag = "R7"; ll(4'd1, 32'h600, 2'd2);
    step(1, 2'd1, 4'd1, 32'h600, 2'd2, 1, 32'h600);
    expect_sc(0);
    step(1, 2'd0, 4'd2, 32'h700, 2'd2, 1, 32'h700);
    sc(4'd2, 32'h700, 2'd2, 1);
    // R8: new LL replaces context's old reservation
    tag = "R8"; ll(4'd3, 32'h800, 2'd2); ll(4'd3, 32'h900, 2'd2);
    sc(4'd3, 32'h800, 2'd2, 0);
    sc(4'd3, 32'h900, 2'd2, 1);
    // R10: no-op code and idle valid leave reservations alone
    tag = "R10"; ll(4'd5, 32'hA00, 2'd2);
    step(1, 2'd3, 4'd5, 32'hA00, 2'd2, 0, 0);
    step(0, 2'd1, 4'd5, 32'hA00, 2'd2, 0, 0);
    step(0, 2'd2, 4'd5, 32'hA00, 2'd2, 0, 0);
    sc(4'd5, 32'hA00, 2'd2, 1);

    // R9: fill, then round-robin eviction from entry 0, lowest free reuse
    tag = "R9";
    do_reset();
    for (int i = 0; i < N; i++) ll(4'(i), 32'h1000 + 32'(i) * 32'h40, 2'd2);
    ll(4'd8, 32'h2000, 2'd2);
    sc(4'd0, 32'h1000, 2'd2, 0);
    sc(4'd1, 32'h1040, 2'd2, 1);
    ll(4'd9, 32'h2040, 2'd2);
    ll(4'd10, 32'h2080, 2'd2);
    sc(4'd9, 32'h2040, 2'd2, 0);
    sc(4'd2, 32'h1080, 2'd2, 1);
    sc(4'd8, 32'h2000, 2'd2, 1);
    sc(4'd10, 32'h2080, 2'd2, 1);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule